// File: doc/BRIEF.md
# CAS-before-RAS Refresh Scheduler

This block keeps a page-mode DRAM alive by running refresh cycles in which the column strobe falls before the row strobe. In that cycle order the memory takes the row from its own internal counter, so the scheduler never drives an address. The write strobe stays high throughout, so the memory does not enter its counter test mode. The data pins stay high-impedance during these cycles.

After reset the scheduler first waits a fixed power-up pause. It then runs a fixed number of initialisation cycles and raises a sticky ready flag. From then on, a periodic timer ticks once per refresh interval, and each tick adds one to a saturating pending count.

The scheduler reaches the strobes through a request/grant handshake with the access sequencer. `req_o` works like a valid signal and `gnt_i` like a ready signal, with these rules:
- The sequencer may keep the grant low for as long as it likes. Pending ticks build up meanwhile, and any beyond the limit are dropped.
- A high request means the sequencer must close any open page at its next safe point and then raise the grant.
- Once granted, the scheduler runs every pending cycle one after another. It lowers `req_o` only when the work is done and the strobes are idle.
- The grant must stay high until the request falls.

Outside its own cycles the scheduler holds all strobes inactive (high).

Top module: `cbr_refresh_sched`

## Requirements
- R1: During and right after reset, `ras_n_o`, `cas_n_o` and `we_n_o` are 1, while `req_o` and `init_done_o` are 0.
- R2: `req_o` stays 0 for the first PAUSE_CYC clock edges after reset is released, and becomes 1 right after edge PAUSE_CYC.
- R3: In every refresh cycle, `cas_n_o` is 0 for at least CSR_CYC cycles before `ras_n_o` falls, and stays 0 for at least CHR_CYC cycles from the fall of `ras_n_o`. `we_n_o` stays 1 at all times.
- R4: `ras_n_o` stays low for exactly RAS_CYC cycles per refresh. It stays high for at least RP_CYC cycles before its next fall.
- R5: After the pause, exactly INIT_CYCLES refresh cycles run before `init_done_o` rises. Once high, `init_done_o` stays high until reset.
- R6: After `init_done_o` rises and while the grant is given promptly, consecutive falls of `ras_n_o` are exactly INTERVAL_CYC cycles apart. 1024 such intervals fit within 16 ms.
- R7: The strobes do not move while `gnt_i` is 0. `req_o` stays 1 while any cycle is running or pending.
- R8: Ticks that arrive without a grant are counted, up to PEND_MAX. When the grant arrives, exactly min(ticks, PEND_MAX) cycles are issued in one burst, after which `req_o` falls.
- R9: Whenever `req_o` is 0, `ras_n_o` and `cas_n_o` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gnt_i | input | 1 | Strobe ownership granted by the access sequencer |
| req_o | output | 1 | Request for strobe ownership |
| ras_n_o | output | 1 | Row strobe, active low, valid while granted |
| cas_n_o | output | 1 | Column strobe, active low, valid while granted |
| we_n_o | output | 1 | Write strobe, held high |
| init_done_o | output | 1 | Power-up initialisation complete (sticky) |

## Verification
The assertions check the following on every clock:
- the column-before-row order at each row-strobe fall;
- the exact row-strobe low width;
- idle strobes whenever no request is raised;
- the grant being held throughout an active cycle;
- the pending count staying within its limit and never going below zero;
- the stickiness of the ready flag.

Some behaviour only the bench's scenarios can show:
- the length of the power-up pause;
- the count of initialisation cycles;
- the exact spacing of periodic refreshes;
- burst sizes that depend on how long the grant was withheld, including the drop of ticks once the count is saturated.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_RASLO = 2'd2,
    PH_PRECH = 2'd3
  } cbr_phase_e;
endpackage

// File: rtl/cbr_tick_timer.sv
module cbr_tick_timer #(
  parameter int unsigned PAUSE_CYC    = 20000,
  parameter int unsigned INTERVAL_CYC = 1560
) (
  input  logic clk,
  input  logic rst_n,
  input  logic init_done_i,
  output logic pause_done_o,
  output logic tick_o
);
  localparam int unsigned LIMIT = (PAUSE_CYC > INTERVAL_CYC) ? PAUSE_CYC : INTERVAL_CYC;
  localparam int unsigned CW    = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q        <= '0;
      pause_done_o <= 1'b0;
      tick_o       <= 1'b0;
    end else begin
      tick_o <= 1'b0;
      if (!pause_done_o) begin
        if (cnt_q == CW'(PAUSE_CYC - 1)) begin
          pause_done_o <= 1'b1;
          cnt_q        <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else if (init_done_i) begin
        if (cnt_q == CW'(INTERVAL_CYC - 1)) begin
          cnt_q  <= '0;
          tick_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  AST_TICK_AFTER_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> init_done_i); // R6
  AST_PAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    pause_done_o |=> pause_done_o); // R2
endmodule

// File: rtl/cbr_pend_ctr.sv
module cbr_pend_ctr #(
  parameter int unsigned PEND_MAX = 7
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          inc_i,
  input  logic                          dec_i,
  output logic [$clog2(PEND_MAX+1)-1:0] count_o
);
  localparam int unsigned PW = $clog2(PEND_MAX + 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_o <= '0;
    end else begin
      case ({inc_i, dec_i})
        2'b10: if (count_o != PW'(PEND_MAX)) count_o <= count_o + 1'b1;
        2'b01: count_o <= count_o - 1'b1;
        default: count_o <= count_o;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (count_o == PW'(PEND_MAX) && inc_i && !dec_i) |=> count_o == PW'(PEND_MAX)); // R8
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    dec_i |-> count_o != '0); // R7
endmodule

// File: rtl/cbr_strobe_fsm.sv
module cbr_strobe_fsm
  import cbr_pkg::*;
#(
  parameter int unsigned INIT_CYCLES = 8,
  parameter int unsigned CSR_CYC     = 1,
  parameter int unsigned CHR_CYC     = 2,
  parameter int unsigned RAS_CYC     = 6,
  parameter int unsigned RP_CYC      = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pause_done_i,
  input  logic pend_nz_i,
  input  logic gnt_i,
  output logic work_o,
  output logic busy_o,
  output logic take_pend_o,
  output logic init_done_o,
  output logic ras_n_o,
  output logic cas_n_o
);
  localparam int unsigned M1   = (CSR_CYC > RAS_CYC) ? CSR_CYC : RAS_CYC;
  localparam int unsigned MLEN = (M1 > RP_CYC) ? M1 : RP_CYC;
  localparam int unsigned PCW  = $clog2(MLEN + 1);
  localparam int unsigned ICW  = $clog2(INIT_CYCLES + 1);

  cbr_phase_e     ph_q;
  logic [PCW-1:0] pc_q;
  logic [ICW-1:0] init_left_q;
  logic           start;
  logic           ras_d, cas_d;

  assign work_o      = pause_done_i && ((init_left_q != '0) || (init_done_o && pend_nz_i));
  assign busy_o      = (ph_q != PH_IDLE);
  assign start       = (ph_q == PH_IDLE) && work_o && gnt_i;
  assign take_pend_o = start && (init_left_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q        <= PH_IDLE;
      pc_q        <= '0;
      init_left_q <= ICW'(INIT_CYCLES);
      init_done_o <= 1'b0;
    end else begin
      pc_q <= pc_q + 1'b1;
      case (ph_q)
        PH_IDLE: begin
          pc_q <= '0;
          if (start) begin
            ph_q <= PH_SETUP;
            if (init_left_q != '0) init_left_q <= init_left_q - 1'b1;
          end else if (pause_done_i && init_left_q == '0) begin
            init_done_o <= 1'b1;
          end
        end
        PH_SETUP: if (pc_q == PCW'(CSR_CYC - 1)) begin ph_q <= PH_RASLO; pc_q <= '0; end
        PH_RASLO: if (pc_q == PCW'(RAS_CYC - 1)) begin ph_q <= PH_PRECH; pc_q <= '0; end
        default:  if (pc_q == PCW'(RP_CYC - 1))  begin ph_q <= PH_IDLE;  pc_q <= '0; end
      endcase
    end
  end

  assign ras_d = (ph_q != PH_RASLO);
  assign cas_d = !((ph_q == PH_SETUP) || (ph_q == PH_RASLO && pc_q < PCW'(CHR_CYC)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_n_o <= 1'b1;
      cas_n_o <= 1'b1;
    end else begin
      ras_n_o <= ras_d;
      cas_n_o <= cas_d;
    end
  end

  AST_GRANT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> gnt_i); // R7
  AST_INIT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    init_done_o |=> init_done_o); // R5
endmodule

// File: rtl/cbr_refresh_sched.sv
module cbr_refresh_sched #(
  parameter int unsigned PAUSE_CYC    = 20000,
  parameter int unsigned INTERVAL_CYC = 1560,
  parameter int unsigned INIT_CYCLES  = 8,
  parameter int unsigned CSR_CYC      = 1,
  parameter int unsigned CHR_CYC      = 2,
  parameter int unsigned RAS_CYC      = 6,
  parameter int unsigned RP_CYC       = 5,
  parameter int unsigned PEND_MAX     = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gnt_i,
  output logic req_o,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic we_n_o,
  output logic init_done_o
);
  localparam int unsigned PW  = $clog2(PEND_MAX + 1);
  localparam int unsigned RLW = $clog2(RAS_CYC + 2);

  logic          pause_done, tick, work, busy, take_pend;
  logic [PW-1:0] pend;

  cbr_tick_timer #(.PAUSE_CYC(PAUSE_CYC), .INTERVAL_CYC(INTERVAL_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .init_done_i(init_done_o),
    .pause_done_o(pause_done), .tick_o(tick)
  );

  cbr_pend_ctr #(.PEND_MAX(PEND_MAX)) u_pend (
    .clk(clk), .rst_n(rst_n), .inc_i(tick), .dec_i(take_pend), .count_o(pend)
  );

  cbr_strobe_fsm #(
    .INIT_CYCLES(INIT_CYCLES), .CSR_CYC(CSR_CYC), .CHR_CYC(CHR_CYC),
    .RAS_CYC(RAS_CYC), .RP_CYC(RP_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .pause_done_i(pause_done), .pend_nz_i(pend != '0),
    .gnt_i(gnt_i), .work_o(work), .busy_o(busy), .take_pend_o(take_pend),
    .init_done_o(init_done_o), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o)
  );

  assign req_o  = work || busy;
  assign we_n_o = 1'b1;

  logic [RLW-1:0] ras_lo_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ras_lo_run <= '0;
    else if (!ras_n_o)   ras_lo_run <= ras_lo_run + 1'b1;
    else                 ras_lo_run <= '0;
  end

  AST_CBR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n_o) |-> (!cas_n_o && $past(!cas_n_o))); // R3
  AST_RAS_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n_o) |-> ras_lo_run == RLW'(RAS_CYC)); // R4
  AST_IDLE_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    !req_o |-> (ras_n_o && cas_n_o)); // R9
endmodule

// File: tb/sim_cbr_refresh_sched.sv
module sim_cbr_refresh_sched;
  localparam int CLK_NS   = 10;
  localparam int PAUSE    = 30;
  localparam int INTERVAL = 100;
  localparam int NINIT    = 8;
  localparam int CSR      = 1;
  localparam int CHR      = 2;
  localparam int RASW     = 6;
  localparam int RP       = 5;
  localparam int PMAX     = 4;
  localparam int NVEC     = 4;
  localparam int VEC_HOLD [NVEC] = '{10, 110, 210, 430};
  localparam int VEC_EXP  [NVEC] = '{1, 2, 3, 4};

  logic clk = 1'b0, rst_n = 1'b0, block = 1'b0;
  logic gnt, req, ras_n, cas_n, we_n, init_done;
  int checks = 0, errors = 0, cyc = 0;

  always #(CLK_NS/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign gnt = req & ~block;

  cbr_refresh_sched #(
    .PAUSE_CYC(PAUSE), .INTERVAL_CYC(INTERVAL), .INIT_CYCLES(NINIT), .CSR_CYC(CSR),
    .CHR_CYC(CHR), .RAS_CYC(RASW), .RP_CYC(RP), .PEND_MAX(PMAX)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .gnt_i(gnt), .req_o(req), .ras_n_o(ras_n),
    .cas_n_o(cas_n), .we_n_o(we_n), .init_done_o(init_done)
  );

  task automatic chk(input bit ok, input string req_tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req_tag, act, exp);
    end
  endtask

  // Strobe waveform monitor (R3, R4)
  int cas_lo_before = 0, cas_lo_after = 0, ras_lo = 0, ras_hi = 100;
  logic p_ras = 1'b1, p_cas = 1'b1;
  always @(negedge clk) begin
    if (rst_n) begin
      if (p_ras && !ras_n) begin
        chk(cas_lo_before >= CSR, "R3 cas lead", cas_lo_before, CSR);
        chk(ras_hi >= RP, "R4 precharge", ras_hi, RP);
        chk(we_n === 1'b1, "R3 write high", we_n, 1);
        cas_lo_after = 0;
      end
      if (!p_ras && ras_n) chk(ras_lo == RASW, "R4 ras width", ras_lo, RASW);
      if (!ras_n && p_cas == 1'b0 && cas_n && !p_ras)
        chk(cas_lo_after >= CHR, "R3 cas hold", cas_lo_after, CHR);
      cas_lo_before = (!cas_n && ras_n) ? cas_lo_before + 1 : 0;
      if (!ras_n && !cas_n) cas_lo_after++;
      ras_lo = ras_n ? 0 : ras_lo + 1;
      ras_hi = ras_n ? ras_hi + 1 : 0;
      p_ras = ras_n;
      p_cas = cas_n;
    end
  end

  task automatic wait_fall(output int at);
    logic p;
    bit seen;
    p = ras_n;
    seen = 0;
    while (!seen) begin
      @(negedge clk);
      if (p && !ras_n) begin at = cyc; seen = 1; end
      p = ras_n;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int t1, t2, falls;
    logic p;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(ras_n && cas_n && we_n, "R1 strobes", {ras_n, cas_n, we_n}, 7);
    chk(!req && !init_done, "R1 req/done", {req, init_done}, 0);
    rst_n = 1'b1;
    // R2 power-up pause
    for (int k = 1; k < PAUSE; k++) begin
      @(negedge clk);
      if (req) chk(0, "R2 early req", k, PAUSE);
    end
    chk(!req, "R2 req before pause", req, 0);
    @(negedge clk);
    chk(req, "R2 req at pause", req, 1);
    // R5 init cycles
    falls = 0;
    p = ras_n;
    while (!init_done) begin
      @(negedge clk);
      if (p && !ras_n) falls++;
      p = ras_n;
    end
    chk(falls == NINIT, "R5 init count", falls, NINIT);
    // R6 periodic spacing
    wait_fall(t1);
    wait_fall(t2);
    chk(t2 - t1 == INTERVAL, "R6 spacing", t2 - t1, INTERVAL);
    chk(longint'(t2 - t1) * 1024 * CLK_NS <= 64'd16000000, "R6 16ms window", (t2 - t1) * 1024 * CLK_NS, 16000000);
    while (req) @(negedge clk);
    block = 1'b1;
    // R7/R8 vectors: withhold grant, then expect a burst
    for (int v = 0; v < NVEC; v++) begin
      while (!req) @(negedge clk);
      for (int h = 0; h < VEC_HOLD[v]; h++) begin
        @(negedge clk);
        if (!(ras_n && cas_n)) chk(0, "R7 strobe moved without grant", {ras_n, cas_n}, 3);
      end
      chk(ras_n && cas_n && req, "R7 idle while held", {ras_n, cas_n, req}, 7);
      block = 1'b0;
      falls = 0;
      p = ras_n;
      while (req) begin
        @(negedge clk);
        if (p && !ras_n) falls++;
        p = ras_n;
      end
      block = 1'b1;
      chk(falls == VEC_EXP[v], "R8 burst size", falls, VEC_EXP[v]);
      chk(ras_n && cas_n, "R9 idle after burst", {ras_n, cas_n}, 3);
    end
    chk(init_done, "R5 sticky", init_done, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule